// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

The unit watches eight dedicated external interrupt pins and turns each into an active-high interrupt request for a parent interrupt controller. Every pin can be set to one of four sense modes: low level, falling edge, rising edge or both edges. Each pin first passes through a synchroniser. An edge detector then works on the synchronised value. A per-pin status bit drives that pin's request line.

Software uses a small 32-bit read/write port that exposes two registers. The status register is at offset 0x10. The sense-select register is at offset 0x14. In the edge modes a status bit latches the event until software writes 0 to it. In low-level mode the bit simply mirrors the synchronised, inverted pin and cannot be cleared. Reads return the live status, so reading the register back after a clear confirms that the clear has taken effect.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every sense field reads 0, every status bit reads 0 and every irq_o line is 0, provided the pins are held high.
- R2: The sense register at offset 0x14 holds a 2-bit field for pin n at bits [2n+1:2n]. It reads back what was written, and bits [31:16] read 0.
- R3: In mode 0 (low level), status bit n equals the inverse of pin n, two clock edges after the pin changes. The bit is not latched, so it returns to 0 when the pin returns high.
- R4: In mode 1 (falling edge), a high-to-low pin transition sets the status bit. A low-to-high transition leaves it unchanged.
- R5: In mode 2 (rising edge), a low-to-high transition sets the status bit. A high-to-low transition leaves it unchanged.
- R6: In mode 3 (both edges), a transition in either direction sets the status bit.
- R7: In an edge mode, a pin transition becomes visible in the status bit and on irq_o after the third rising clock edge that follows it, and not earlier. The bit stays set after the pin returns.
- R8: Writing offset 0x10 clears status bit n when data bit n is 0 and pin n is in an edge mode. Data bits that are 1 leave their status bits unchanged.
- R9: In mode 0, writing 0 to the status bit has no effect: the bit keeps following the pin.
- R10: When a detected edge and a clear of the same pin fall in the same cycle, the status bit ends up set.
- R11: A read of offset 0x10 returns the status bits in bits [7:0], equal to irq_o. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | External interrupt pins, asynchronous |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 8 | Active-high interrupt requests to the parent |

## Verification
The bench builds the block with its default parameters: eight pins, a two-stage synchroniser and an 8-bit offset. These values make the exact three-edge latency from a pin transition to irq_o observable. They also let one cycle be lined up so that an edge and a clear write land on the same clock edge. All four sense codes are set on different pins within a single sense word, which exposes any field that is misplaced or crosses into its neighbour.

// File: rtl/eis_pkg.sv
package eis_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eis_pin.sv
module eis_pin
  import eis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_i,
  input  sense_e mode_i,
  input  logic   clr_i,
  output logic   status_o
);
  logic pin_s, pin_d, fall, rise, hit, flag_q;

  eis_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_d <= 1'b1;
    else         pin_d <= pin_s;
  end

  assign fall = pin_d & ~pin_s;
  assign rise = ~pin_d & pin_s;

  always_comb begin
    unique case (mode_i)
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      SENSE_BOTH: hit = fall | rise;
      default:    hit = 1'b0;
    endcase
  end

  // edge beats clear; flag parked at 0 in level mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  flag_q <= 1'b0;
    else if (mode_i == SENSE_LOW) flag_q <= 1'b0;
    else if (hit)                 flag_q <= 1'b1;
    else if (clr_i)               flag_q <= 1'b0;
  end

  assign status_o = (mode_i == SENSE_LOW) ? ~pin_s : flag_q;

  a_r10_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != SENSE_LOW && hit) |=> flag_q);

  a_r8_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != SENSE_LOW && clr_i && !hit) |=> !flag_q);

  a_r7_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != SENSE_LOW && flag_q && !clr_i) |=> flag_q);

  a_r4_rise_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_FALL && !flag_q && !(pin_d && !pin_s)) |=> !flag_q);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int          NUM_PINS    = 8,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned STATUS_OFF  = 'h10,
  parameter int unsigned SENSE_OFF   = 'h14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_PINS-1:0] irq_o
);
  localparam int SENSE_W = 2 * NUM_PINS;

  logic [SENSE_W-1:0]  sense_q;
  logic [NUM_PINS-1:0] status, clr_vec;
  logic                hit_status, hit_sense, wr_status, wr_sense;

  assign hit_status = (addr_i == ADDR_W'(STATUS_OFF));
  assign hit_sense  = (addr_i == ADDR_W'(SENSE_OFF));
  assign wr_status  = req_i & we_i & hit_status;
  assign wr_sense   = req_i & we_i & hit_sense;
  assign clr_vec    = {NUM_PINS{wr_status}} & ~wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sense_q <= '0;
    else if (wr_sense) sense_q <= wdata_i[SENSE_W-1:0];
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    eis_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pins_i[n]),
      .mode_i  (sense_e'(sense_q[2*n +: 2])),
      .clr_i   (clr_vec[n]),
      .status_o(status[n])
    );
  end

  if (SENSE_W < DATA_W) begin : g_spare
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:SENSE_W];
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (hit_status)     rdata_o[NUM_PINS-1:0] = status;
      else if (hit_sense) rdata_o[SENSE_W-1:0]  = sense_q;
    end
  end

  assign irq_o = status;

  a_r2_sense_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sense |=> sense_q == $past(wdata_i[SENSE_W-1:0]));

  a_r11_read_matches_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && hit_status) |-> rdata_o[NUM_PINS-1:0] == irq_o);
endmodule

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  localparam logic [7:0] A_STAT  = 8'h10;
  localparam logic [7:0] A_SENSE = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = 8'hFF;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  irq;
  logic [15:0] sense_w = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic set_mode(input int p, input logic [1:0] m);
    sense_w[2*p +: 2] = m;
    bus_write(A_SENSE, {16'h0, sense_w});
  endtask

  task automatic drive(input int p, input logic v);
    @(negedge clk); pins[p] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(A_SENSE, d); chk("R1 sense", d, 0);
    bus_read(A_STAT, d);  chk("R1 status", d, 0);
    chk("R1 irq", {24'h0, irq}, 0);
  endtask

  task automatic t_sense_reg();
    logic [31:0] d;
    bus_write(A_SENSE, 32'hFFFF_FFFF);
    bus_read(A_SENSE, d); chk("R2 upper zero", d, 32'h0000_FFFF);
    bus_write(A_SENSE, 32'h0000_1BE4);
    bus_read(A_SENSE, d); chk("R2 fields", d, 32'h0000_1BE4);
    bus_read(8'h00, d);   chk("R11 other offset", d, 0);
    bus_write(A_SENSE, 0);
    sense_w = '0;
    settle();
  endtask

  task automatic t_level();
    logic [31:0] d;
    drive(2, 0);
    @(posedge clk); @(negedge clk); chk("R3 before 2 edges", {31'h0, irq[2]}, 0);
    @(posedge clk); @(negedge clk); chk("R3 after 2 edges", {31'h0, irq[2]}, 1);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); chk("R9 level not cleared", d, 32'h04);
    drive(2, 1);
    settle(); chk("R3 not latched", {24'h0, irq}, 0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    set_mode(0, 2'd1);
    drive(0, 0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7 not before 3rd edge", {31'h0, irq[0]}, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 at 3rd edge", {31'h0, irq[0]}, 1);
    drive(0, 1); settle();
    bus_read(A_STAT, d); chk("R7 latched", d, 32'h01);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); chk("R8 clear", d, 0);
    drive(0, 0); settle(); chk("R4 falling sets", {31'h0, irq[0]}, 1);
    bus_write(A_STAT, 32'h0);
    drive(0, 1); settle(); chk("R4 rising ignored", {31'h0, irq[0]}, 0);
  endtask

  task automatic t_rise();
    set_mode(1, 2'd2);
    drive(1, 0); settle(); chk("R5 falling ignored", {31'h0, irq[1]}, 0);
    drive(1, 1); settle(); chk("R5 rising sets", {31'h0, irq[1]}, 1);
  endtask

  task automatic t_both();
    set_mode(3, 2'd3);
    drive(3, 0); settle(); chk("R6 fall sets", {31'h0, irq[3]}, 1);
    bus_write(A_STAT, 32'hFFFF_FFF7);
    settle(); chk("R6 cleared", {31'h0, irq[3]}, 0);
    drive(3, 1); settle(); chk("R6 rise sets", {31'h0, irq[3]}, 1);
    bus_write(A_STAT, 32'hFFFF_FFF7);
  endtask

  task automatic t_write_one();
    logic [31:0] d;
    set_mode(4, 2'd2);
    drive(4, 0); drive(4, 1); settle();
    bus_write(A_STAT, 32'hFFFF_FFFF);
    bus_read(A_STAT, d); chk("R8 write 1 no effect", d, 32'h12);
    bus_write(A_STAT, 32'hFFFF_FFEF);
    bus_read(A_STAT, d); chk("R8 only bit4 cleared", d, 32'h02);
    chk("R11 irq equals status", {24'h0, irq}, 32'h02);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    set_mode(5, 2'd3);
    drive(5, 0); settle();
    drive(5, 1);
    @(posedge clk); @(posedge clk);
    bus_write(A_STAT, 32'hFFFF_FFDF);
    bus_read(A_STAT, d); chk("R10 edge beats clear", d & 32'h20, 32'h20);
    bus_write(A_STAT, 32'hFFFF_FFDF);
    bus_read(A_STAT, d); chk("R10 later clear works", d & 32'h20, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sense_reg();
    t_level();
    t_fall();
    t_rise();
    t_both();
    t_write_one();
    t_collide();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule